// File: doc/BRIEF.md
# Predicated Stream Port Pair

This block holds both ends of a flow-controlled channel between two independently scheduled kernels. On the producer side, the kernel offers a word together with a predicate. The predicate says whether the scheduled transfer really happens in this cycle. The word goes into an eight-entry buffer, and that buffer drains onto an outgoing valid/ready link. On the consumer side, words arriving on an incoming valid/ready link are buffered. The kernel takes them when its read predicate is set.

Each end raises a stall request when an active predicate cannot be served. The kernel's stall network then freezes the kernel, which shows up as the `kstall` input. That network has latency, so the write side raises its stall early, at a programmable high-water mark. This leaves room for writes the kernel issues before the freeze takes effect. The read side has a probe input so that emptiness can be tested ahead of the actual data use.

Top module: `pred_stream_port`

## Requirements
- R1: While reset is low and right after it: `tx_valid`=0, `rx_ready`=1, `wr_ovf`=0, and both stall requests are 0 when no predicate or probe is set.
- R2: `wr_stall_req` is 1 exactly when `wr_pred`=1 and the write buffer holds at least the effective mark. It is 0 whenever `wr_pred`=0.
- R3: A predicated write with `kstall`=0 is stored whenever fewer than 8 words are buffered, even when `wr_stall_req` is high.
- R4: A predicated write with `kstall`=0 that meets 8 buffered words is dropped. A simultaneous link pop does not make room for it. The drop sets `wr_ovf`, which stays 1 until reset.
- R5: `tx_valid` is 1 while the write buffer is not empty. `tx_data` shows the oldest word and holds while `tx_ready`=0. One word leaves per cycle with `tx_valid`&`tx_ready`, in write order.
- R6: `rx_ready` is 1 while the read buffer holds fewer than 8 words. A word is taken on each edge with `rx_valid`&`rx_ready`. A word offered while `rx_ready`=0 is not stored.
- R7: `rd_stall_req` is 1 exactly when (`rd_pred` or `rd_probe`) is 1 and the read buffer is empty.
- R8: `rd_data` shows the oldest buffered word. A predicated read with `kstall`=0 on a non-empty buffer removes it, and words come out in arrival order.
- R9: While `kstall`=1, no kernel write is stored and no kernel read removes a word. Both links keep transferring.
- R10: The effective mark equals `hwm` for values 1 to 8. A value of 0 acts as 1, and values above 8 act as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hwm | input | 4 | Write high-water mark |
| kstall | input | 1 | Kernel is frozen this cycle |
| wr_pred | input | 1 | Kernel performs the scheduled write |
| wr_data | input | 32 | Word to write |
| wr_stall_req | output | 1 | Write side asks for a kernel stall |
| wr_ovf | output | 1 | Sticky: a write was lost on true overflow |
| tx_valid | output | 1 | Outgoing link word present |
| tx_data | output | 32 | Outgoing link word |
| tx_ready | input | 1 | Downstream can take a word |
| rx_valid | input | 1 | Incoming link word present |
| rx_data | input | 32 | Incoming link word |
| rx_ready | output | 1 | This end can take a word |
| rd_probe | input | 1 | Early emptiness probe |
| rd_pred | input | 1 | Kernel performs the scheduled read |
| rd_data | output | 32 | Oldest buffered incoming word |
| rd_stall_req | output | 1 | Read side asks for a kernel stall |

## Verification
Two functions can fall in the same cycle: a kernel freeze and a link transfer on the same buffer. The freeze must block only the kernel side, while the link side keeps moving.

The bench provokes this on the write side by holding `kstall` with `tx_ready` high over a loaded buffer. It provokes it on the read side by offering an incoming word and a predicated read during `kstall`. It judges the result at the ports. The write buffer must empty with no new word added. The held `rd_data` must not advance. The word that arrived during the freeze must be readable afterwards.

// File: rtl/pred_stream_port.sv
module pred_stream_port #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] hwm,
  input  logic          kstall,
  input  logic          wr_pred,
  input  logic [DW-1:0] wr_data,
  output logic          wr_stall_req,
  output logic          wr_ovf,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  input  logic          rd_probe,
  input  logic          rd_pred,
  output logic [DW-1:0] rd_data,
  output logic          rd_stall_req
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  // producer side
  logic [DW-1:0] wmem [DEPTH];
  logic [AW-1:0] w_head, w_tail;
  logic [CW-1:0] w_cnt, mark;
  logic          w_try, w_push, w_drop, w_pop;

  assign mark = (hwm == '0) ? CW'(1) : (hwm > FULL) ? FULL : hwm;
  assign w_try  = wr_pred && !kstall;
  assign w_push = w_try && (w_cnt != FULL);
  assign w_drop = w_try && (w_cnt == FULL);
  assign w_pop  = tx_valid && tx_ready;
  assign tx_valid = (w_cnt != '0);
  assign tx_data  = wmem[w_head];
  assign wr_stall_req = wr_pred && (w_cnt >= mark);

  always_ff @(posedge clk)
    if (w_push) wmem[w_tail] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_head <= '0;
      w_tail <= '0;
      w_cnt  <= '0;
      wr_ovf <= 1'b0;
    end else begin
      if (w_push) w_tail <= w_tail + AW'(1);
      if (w_pop)  w_head <= w_head + AW'(1);
      w_cnt <= w_cnt + CW'(w_push) - CW'(w_pop);
      if (w_drop) wr_ovf <= 1'b1;
    end
  end

  // consumer side
  logic [DW-1:0] rmem [DEPTH];
  logic [AW-1:0] r_head, r_tail;
  logic [CW-1:0] r_cnt;
  logic          r_push, r_pop;

  assign rx_ready = (r_cnt != FULL);
  assign r_push   = rx_valid && rx_ready;
  assign r_pop    = rd_pred && !kstall && (r_cnt != '0);
  assign rd_data  = rmem[r_head];
  assign rd_stall_req = (rd_pred || rd_probe) && (r_cnt == '0);

  always_ff @(posedge clk)
    if (r_push) rmem[r_tail] <= rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_head <= '0;
      r_tail <= '0;
      r_cnt  <= '0;
    end else begin
      if (r_push) r_tail <= r_tail + AW'(1);
      if (r_pop)  r_head <= r_head + AW'(1);
      r_cnt <= r_cnt + CW'(r_push) - CW'(r_pop);
    end
  end

  // checks
  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    w_cnt <= FULL && r_cnt <= FULL);
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovf |=> wr_ovf);
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  p_rx_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> r_cnt != '0);
  p_no_push_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kstall |=> w_cnt <= $past(w_cnt));
  p_no_pop_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kstall |=> r_cnt >= $past(r_cnt));
endmodule

// File: tb/pred_stream_port_bench.sv
`timescale 1ns/100ps
module pred_stream_port_bench;
  logic clk = 0, rst_n = 0;
  logic [3:0] hwm = 4'd8;
  logic kstall = 0, wr_pred = 0, tx_ready = 0, rx_valid = 0, rd_probe = 0, rd_pred = 0;
  logic [31:0] wr_data = 0, rx_data = 0;
  logic wr_stall_req, wr_ovf, tx_valid, rx_ready, rd_stall_req;
  logic [31:0] tx_data, rd_data;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  pred_stream_port u_pred_stream_port (
    .clk(clk), .rst_n(rst_n), .hwm(hwm), .kstall(kstall),
    .wr_pred(wr_pred), .wr_data(wr_data), .wr_stall_req(wr_stall_req), .wr_ovf(wr_ovf),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rd_probe(rd_probe), .rd_pred(rd_pred), .rd_data(rd_data), .rd_stall_req(rd_stall_req));

  // {hwm[3:0], fill[3:0], pred, expected stall}
  localparam logic [9:0] VEC [10] = '{
    {4'd1, 4'd0, 1'b1, 1'b0}, {4'd1, 4'd1, 1'b1, 1'b1},
    {4'd4, 4'd3, 1'b1, 1'b0}, {4'd4, 4'd4, 1'b1, 1'b1},
    {4'd4, 4'd6, 1'b0, 1'b0}, {4'd8, 4'd7, 1'b1, 1'b0},
    {4'd8, 4'd8, 1'b1, 1'b1}, {4'd0, 4'd1, 1'b1, 1'b1},
    {4'd12, 4'd7, 1'b1, 1'b0}, {4'd12, 4'd8, 1'b1, 1'b1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
  endtask

  task automatic fill_wr(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) wr_pred = 1; wr_data = base + i;
    end
    @(negedge clk) wr_pred = 0;
  endtask

  task automatic fill_rx(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rx_valid = 1; rx_data = base + i;
    end
    @(negedge clk) rx_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tx_valid in reset", tx_valid, 0);
    chk("R1 rx_ready in reset", rx_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 wr_ovf", wr_ovf, 0);
    chk("R1 stall reqs", {wr_stall_req, rd_stall_req}, 0);

    // R2 / R10 table walk
    for (int i = 0; i < 10; i++) begin
      do_reset();
      hwm = VEC[i][9:6];
      fill_wr(int'(VEC[i][5:2]), 16 * i);
      wr_pred = VEC[i][1];
      #1 chk($sformatf("R2 R10 vec %0d", i), wr_stall_req, VEC[i][0]);
      wr_pred = 0;
    end

    // R3 accept above mark, R4 overflow, R5 drain order
    do_reset();
    hwm = 4'd2;
    fill_wr(8, 100);
    chk("R3 no loss above mark", wr_ovf, 0);
    wr_pred = 1; wr_data = 999;
    @(negedge clk) wr_pred = 0;
    chk("R4 overflow flag", wr_ovf, 1);
    tx_ready = 1;
    for (int i = 0; i < 8; i++) begin
      #1 chk("R5 tx order", tx_data, 100 + i);
      @(negedge clk);
    end
    chk("R4 dropped word absent", tx_valid, 0);
    chk("R4 flag sticky", wr_ovf, 1);
    tx_ready = 0;

    // R4: full buffer, kernel write and link pop in one cycle
    do_reset();
    fill_wr(8, 500);
    wr_pred = 1; wr_data = 777; tx_ready = 1;
    @(negedge clk) wr_pred = 0; tx_ready = 0;
    chk("R4 pop does not make room", wr_ovf, 1);

    // R9 write side: frozen kernel, link keeps draining
    do_reset();
    fill_wr(2, 50);
    kstall = 1; wr_pred = 1; wr_data = 60; tx_ready = 1;
    repeat (3) @(negedge clk);
    chk("R9 frozen write not stored, link drained", tx_valid, 0);
    kstall = 0; wr_pred = 0; tx_ready = 0;

    // R6 / R7 / R8 / R9 read side
    do_reset();
    rd_probe = 1;
    #1 chk("R7 probe on empty", rd_stall_req, 1);
    rd_probe = 0;
    fill_rx(8, 200);
    chk("R6 full deasserts ready", rx_ready, 0);
    rx_valid = 1; rx_data = 300;
    @(negedge clk) rx_valid = 0;
    rd_pred = 1;
    #1 chk("R7 no stall when data", rd_stall_req, 0);
    kstall = 1;
    @(negedge clk) kstall = 0;
    chk("R9 frozen read keeps head", rd_data, 200);
    for (int i = 0; i < 8; i++) begin
      #1 chk("R8 rd order", rd_data, 200 + i);
      @(negedge clk);
    end
    rd_pred = 0;
    #1 chk("R7 idle no stall", rd_stall_req, 0);
    rd_pred = 1;
    #1 chk("R6 word refused when full", rd_stall_req, 1);
    rd_pred = 0;
    kstall = 1; rx_valid = 1; rx_data = 400;
    @(negedge clk) rx_valid = 0; kstall = 0;
    chk("R9 link receives while frozen", rd_data, 400);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule